// File: doc/BRIEF.md
# Memory Access Router and Fault Checker

This block sits between a load/store pipeline and two downstream targets: a device-register port and a physical-memory port. Each request it accepts carries an address, a size code, a kind (instruction fetch or data), a direction, and three ordering flags: acquire, release, and reserved/conditional. The block checks alignment where the flags require it. It then compares the first and last byte of the access against parameterised address windows. Based on that, it sends the access to one of the two ports or raises an exception with a typed 4-bit cause code.

Only plain data accesses can reach device registers. Any access with an ordering or reservation flag goes straight to the memory port once its alignment check has passed. The memory port can reject an access, and the block turns each rejection into the cause code that matches the access kind. Read data, write completions and faults all return on one response channel with a valid/ready handshake. At most one request is in flight at a time.

Top module: `mem_route_unit`

## Requirements
- R1: The size code maps as follows: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. An access is aligned when its unsigned address modulo that byte count is zero. An aligned ordered access is never treated as misaligned.
- R2: A read with acquire or reserved set and a misaligned address responds with error set and cause 4. Neither port is accessed.
- R3: A write with release or conditional set and a misaligned address responds with error set and cause 6. Neither port is accessed.
- R4: An access with any of acquire, release or reserved/conditional set that passes R2/R3 goes to the memory port. The window checks do not apply to it.
- R5: A plain data read whose bytes all lie in the device read window goes to the device port. The device data is returned with error clear.
- R6: A fetch never goes to the device port. A plain fetch, or a plain data read outside the device read window, goes to the memory port when its bytes lie in the memory range. Otherwise it responds with cause 5.
- R7: When the memory port rejects a read, the cause is 1 for a fetch and 5 for a data read.
- R8: A plain write goes to the device port if its bytes lie in the device write window. Otherwise it goes to the memory port if they lie in the memory range. Otherwise it responds with cause 7. A memory rejection of any write gives cause 7.
- R9: A window contains an access only when both its first byte and its last byte lie within the inclusive bounds. An access that straddles a window edge is outside that window.
- R10: The response holds its valid, error, cause and data stable until it is accepted. Data is zero for writes and for errors. Request-ready stays low from acceptance until the response is accepted.
- R11: The selected port receives the request's address, size code, direction and write data unchanged, and keeps its request valid until that port is ready. The two request valids are never high together.
- R12: After reset, request-ready is high and no valid output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Size code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_aq | input | 1 | Acquire ordering |
| req_rl | input | 1 | Release ordering |
| req_rsv | input | 1 | Reserved read / conditional write |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | DW | Read data, zero for writes and errors |
| rsp_err | output | 1 | Exception raised |
| rsp_cause | output | 4 | Exception cause code |
| dev_req_valid | output | 1 | Device port request |
| dev_req_ready | input | 1 | Device port accepts |
| dev_addr | output | AW | Device address |
| dev_size | output | 2 | Device size code |
| dev_write | output | 1 | Device direction |
| dev_wdata | output | DW | Device write data |
| dev_rsp_valid | input | 1 | Device response |
| dev_rsp_rdata | input | DW | Device read data |
| mem_req_valid | output | 1 | Memory port request |
| mem_req_ready | input | 1 | Memory port accepts |
| mem_addr | output | AW | Memory address |
| mem_size | output | 2 | Memory size code |
| mem_write | output | 1 | Memory direction |
| mem_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_rdata | input | DW | Memory read data |
| mem_rsp_err | input | 1 | Memory rejected the access |

## Verification
The sweep probes addresses on either side of every window edge at all four sizes, under every combination of fetch, direction and flags. A design that compares only the first byte would send straddling accesses into a window. A design that applies the strict alignment rule to the wrong flag would fault an acquire write or let a misaligned reserved read through. Fetches aimed at the device read window catch a router that treats fetches like data. Memory rejections of fetches, data reads and writes catch a swapped cause code. Held-off responses catch a response that changes or drops before it is accepted.

// File: rtl/mem_route_pkg.sv
package mem_route_pkg;
   localparam int SIZE_W  = 2;
   localparam int CAUSE_W = 4;

   localparam logic [CAUSE_W-1:0] C_FETCH_ACC = 4'd1;
   localparam logic [CAUSE_W-1:0] C_LD_MISAL  = 4'd4;
   localparam logic [CAUSE_W-1:0] C_LD_ACC    = 4'd5;
   localparam logic [CAUSE_W-1:0] C_ST_MISAL  = 4'd6;
   localparam logic [CAUSE_W-1:0] C_ST_ACC    = 4'd7;

   typedef enum logic [1:0] {
      RT_FAULT = 2'd0,
      RT_DEV   = 2'd1,
      RT_MEM   = 2'd2
   } route_e;

   typedef enum logic [2:0] {
      S_IDLE     = 3'd0,
      S_DEV_REQ  = 3'd1,
      S_DEV_WAIT = 3'd2,
      S_MEM_REQ  = 3'd3,
      S_MEM_WAIT = 3'd4,
      S_RSP      = 3'd5
   } state_e;
endpackage

// File: rtl/mem_route_window.sv
module mem_route_window
   import mem_route_pkg::*;
#(
   parameter int            AW   = 32,
   parameter logic [AW-1:0] BASE = '0,
   parameter logic [AW-1:0] LAST = '0
) (
   input  logic [AW-1:0]     addr,
   input  logic [SIZE_W-1:0] size,
   output logic              hit
);
   logic [AW:0] last_byte;

   always_comb begin
      last_byte = {1'b0, addr} + ((AW+1)'(1) << size) - (AW+1)'(1);
      hit       = (addr >= BASE) && (last_byte <= {1'b0, LAST});
   end
endmodule

// File: rtl/mem_route_decode.sv
module mem_route_decode
   import mem_route_pkg::*;
#(
   parameter int            AW       = 32,
   parameter logic [AW-1:0] MEM_BASE = '0,
   parameter logic [AW-1:0] MEM_LAST = '0,
   parameter logic [AW-1:0] DRD_BASE = '0,
   parameter logic [AW-1:0] DRD_LAST = '0,
   parameter logic [AW-1:0] DWR_BASE = '0,
   parameter logic [AW-1:0] DWR_LAST = '0
) (
   input  logic [AW-1:0]      addr,
   input  logic [SIZE_W-1:0]  size,
   input  logic               fetch,
   input  logic               write,
   input  logic               aq,
   input  logic               rl,
   input  logic               rsv,
   output route_e             route,
   output logic [CAUSE_W-1:0] cause
);
   localparam int NWIN    = 3;
   localparam int WIN_MEM = 0;
   localparam int WIN_DRD = 1;
   localparam int WIN_DWR = 2;
   localparam logic [NWIN*AW-1:0] BASES = {DWR_BASE, DRD_BASE, MEM_BASE};
   localparam logic [NWIN*AW-1:0] LASTS = {DWR_LAST, DRD_LAST, MEM_LAST};

   logic [NWIN-1:0] hit;
   logic [3:0]      span;
   logic            mis;
   logic            ordered;

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      if (BASES[g*AW +: AW] > LASTS[g*AW +: AW]) begin : g_bad_bounds
         $error("window %0d has base above last byte", g);
      end
      mem_route_window #(
         .AW   (AW),
         .BASE (BASES[g*AW +: AW]),
         .LAST (LASTS[g*AW +: AW])
      ) u_win (
         .addr (addr),
         .size (size),
         .hit  (hit[g])
      );
   end

   always_comb begin
      span    = 4'(1) << size;
      mis     = |(addr[2:0] & 3'(span - 4'd1));
      ordered = aq | rl | rsv;
      route   = RT_FAULT;
      cause   = '0;
      if (write) begin
         if ((rl | rsv) && mis)  cause = C_ST_MISAL;
         else if (ordered)       route = RT_MEM;
         else if (hit[WIN_DWR])  route = RT_DEV;
         else if (hit[WIN_MEM])  route = RT_MEM;
         else                    cause = C_ST_ACC;
      end else begin
         if ((aq | rsv) && mis)          cause = C_LD_MISAL;
         else if (ordered)               route = RT_MEM;
         else if (!fetch && hit[WIN_DRD]) route = RT_DEV;
         else if (hit[WIN_MEM])          route = RT_MEM;
         else                            cause = C_LD_ACC;
      end
   end
endmodule

// File: rtl/mem_route_ctrl.sv
module mem_route_ctrl
   import mem_route_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [AW-1:0]      req_addr,
   input  logic [SIZE_W-1:0]  req_size,
   input  logic               req_fetch,
   input  logic               req_write,
   input  logic [DW-1:0]      req_wdata,
   input  route_e             dec_route,
   input  logic [CAUSE_W-1:0] dec_cause,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [DW-1:0]      rsp_rdata,
   output logic               rsp_err,
   output logic [CAUSE_W-1:0] rsp_cause,
   output logic               dev_req_valid,
   input  logic               dev_req_ready,
   input  logic               dev_rsp_valid,
   input  logic [DW-1:0]      dev_rsp_rdata,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   input  logic               mem_rsp_valid,
   input  logic [DW-1:0]      mem_rsp_rdata,
   input  logic               mem_rsp_err,
   output logic [AW-1:0]      fwd_addr,
   output logic [SIZE_W-1:0]  fwd_size,
   output logic               fwd_write,
   output logic [DW-1:0]      fwd_wdata
);
   state_e             state_q;
   logic               fetch_q;
   logic [DW-1:0]      rdata_q;
   logic               err_q;
   logic [CAUSE_W-1:0] cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         fwd_addr  <= '0;
         fwd_size  <= '0;
         fwd_write <= 1'b0;
         fwd_wdata <= '0;
         fetch_q   <= 1'b0;
         rdata_q   <= '0;
         err_q     <= 1'b0;
         cause_q   <= '0;
      end else begin
         case (state_q)
            S_IDLE: if (req_valid) begin
               fwd_addr  <= req_addr;
               fwd_size  <= req_size;
               fwd_write <= req_write;
               fwd_wdata <= req_wdata;
               fetch_q   <= req_fetch;
               rdata_q   <= '0;
               err_q     <= (dec_route == RT_FAULT);
               cause_q   <= dec_cause;
               case (dec_route)
                  RT_DEV:  state_q <= S_DEV_REQ;
                  RT_MEM:  state_q <= S_MEM_REQ;
                  default: state_q <= S_RSP;
               endcase
            end
            S_DEV_REQ: if (dev_req_ready) state_q <= S_DEV_WAIT;
            S_DEV_WAIT: if (dev_rsp_valid) begin
               if (!fwd_write) rdata_q <= dev_rsp_rdata;
               state_q <= S_RSP;
            end
            S_MEM_REQ: if (mem_req_ready) state_q <= S_MEM_WAIT;
            S_MEM_WAIT: if (mem_rsp_valid) begin
               if (mem_rsp_err) begin
                  err_q   <= 1'b1;
                  cause_q <= fwd_write ? C_ST_ACC : (fetch_q ? C_FETCH_ACC : C_LD_ACC);
               end else if (!fwd_write) begin
                  rdata_q <= mem_rsp_rdata;
               end
               state_q <= S_RSP;
            end
            S_RSP: if (rsp_ready) state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == S_IDLE);
   assign dev_req_valid = (state_q == S_DEV_REQ);
   assign mem_req_valid = (state_q == S_MEM_REQ);
   assign rsp_valid     = (state_q == S_RSP);
   assign rsp_rdata     = rdata_q;
   assign rsp_err       = err_q;
   assign rsp_cause     = cause_q;
endmodule

// File: rtl/mem_route_unit.sv
module mem_route_unit
   import mem_route_pkg::*;
#(
   parameter int            AW       = 32,
   parameter int            DW       = 64,
   parameter logic [AW-1:0] MEM_BASE = AW'(32'h8000_0000),
   parameter logic [AW-1:0] MEM_LAST = AW'(32'h8FFF_FFFF),
   parameter logic [AW-1:0] DRD_BASE = AW'(32'h0200_0000),
   parameter logic [AW-1:0] DRD_LAST = AW'(32'h0200_FFFF),
   parameter logic [AW-1:0] DWR_BASE = AW'(32'h0200_0000),
   parameter logic [AW-1:0] DWR_LAST = AW'(32'h0200_FFFF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [AW-1:0]      req_addr,
   input  logic [1:0]         req_size,
   input  logic               req_fetch,
   input  logic               req_write,
   input  logic               req_aq,
   input  logic               req_rl,
   input  logic               req_rsv,
   input  logic [DW-1:0]      req_wdata,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [DW-1:0]      rsp_rdata,
   output logic               rsp_err,
   output logic [3:0]         rsp_cause,
   output logic               dev_req_valid,
   input  logic               dev_req_ready,
   output logic [AW-1:0]      dev_addr,
   output logic [1:0]         dev_size,
   output logic               dev_write,
   output logic [DW-1:0]      dev_wdata,
   input  logic               dev_rsp_valid,
   input  logic [DW-1:0]      dev_rsp_rdata,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [AW-1:0]      mem_addr,
   output logic [1:0]         mem_size,
   output logic               mem_write,
   output logic [DW-1:0]      mem_wdata,
   input  logic               mem_rsp_valid,
   input  logic [DW-1:0]      mem_rsp_rdata,
   input  logic               mem_rsp_err
);
   if (AW < 4) begin : g_bad_aw
      $error("address width must be at least 4 bits");
   end
   if (DW < 64 || (DW % 8) != 0) begin : g_bad_dw
      $error("data width must hold an 8-byte access in whole bytes");
   end

   route_e             dec_route;
   logic [CAUSE_W-1:0] dec_cause;
   logic [AW-1:0]      fwd_addr;
   logic [SIZE_W-1:0]  fwd_size;
   logic               fwd_write;
   logic [DW-1:0]      fwd_wdata;

   mem_route_decode #(
      .AW (AW), .MEM_BASE (MEM_BASE), .MEM_LAST (MEM_LAST),
      .DRD_BASE (DRD_BASE), .DRD_LAST (DRD_LAST),
      .DWR_BASE (DWR_BASE), .DWR_LAST (DWR_LAST)
   ) u_decode (
      .addr  (req_addr),
      .size  (req_size),
      .fetch (req_fetch),
      .write (req_write),
      .aq    (req_aq),
      .rl    (req_rl),
      .rsv   (req_rsv),
      .route (dec_route),
      .cause (dec_cause)
   );

   mem_route_ctrl #(.AW (AW), .DW (DW)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_addr      (req_addr),
      .req_size      (req_size),
      .req_fetch     (req_fetch),
      .req_write     (req_write),
      .req_wdata     (req_wdata),
      .dec_route     (dec_route),
      .dec_cause     (dec_cause),
      .rsp_valid     (rsp_valid),
      .rsp_ready     (rsp_ready),
      .rsp_rdata     (rsp_rdata),
      .rsp_err       (rsp_err),
      .rsp_cause     (rsp_cause),
      .dev_req_valid (dev_req_valid),
      .dev_req_ready (dev_req_ready),
      .dev_rsp_valid (dev_rsp_valid),
      .dev_rsp_rdata (dev_rsp_rdata),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_rdata (mem_rsp_rdata),
      .mem_rsp_err   (mem_rsp_err),
      .fwd_addr      (fwd_addr),
      .fwd_size      (fwd_size),
      .fwd_write     (fwd_write),
      .fwd_wdata     (fwd_wdata)
   );

   assign dev_addr  = fwd_addr;
   assign dev_size  = fwd_size;
   assign dev_write = fwd_write;
   assign dev_wdata = fwd_wdata;
   assign mem_addr  = fwd_addr;
   assign mem_size  = fwd_size;
   assign mem_write = fwd_write;
   assign mem_wdata = fwd_wdata;
endmodule

// File: rtl/mem_route_checker.sv
module mem_route_checker #(
   parameter int AW = 32,
   parameter int DW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [AW-1:0] req_addr,
   input logic [1:0]    req_size,
   input logic          req_fetch,
   input logic          req_write,
   input logic          req_aq,
   input logic          req_rl,
   input logic          req_rsv,
   input logic          rsp_valid,
   input logic          rsp_ready,
   input logic [DW-1:0] rsp_rdata,
   input logic          rsp_err,
   input logic [3:0]    rsp_cause,
   input logic          dev_req_valid,
   input logic          dev_req_ready,
   input logic [AW-1:0] dev_addr,
   input logic          mem_req_valid,
   input logic          mem_req_ready,
   input logic [AW-1:0] mem_addr
);
   logic       accept;
   logic [2:0] low_bits;
   logic       req_mis;

   always_comb begin
      accept   = req_valid && req_ready;
      low_bits = req_addr[2:0] & 3'((4'(1) << req_size) - 4'd1);
      req_mis  = (low_bits != 3'd0);
   end

   a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !rsp_valid && !dev_req_valid && !mem_req_valid);

   a_r11_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_req_valid && mem_req_valid));

   a_r11_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req_valid && !dev_req_ready |=> dev_req_valid && $stable(dev_addr));

   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

   a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)
                                  && $stable(rsp_err) && $stable(rsp_cause));

   a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   a_r2_load_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !req_write && (req_aq || req_rsv) && req_mis
      |=> rsp_valid && rsp_err && (rsp_cause == 4'd4));

   a_r3_store_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
      accept && req_write && (req_rl || req_rsv) && req_mis
      |=> rsp_valid && rsp_err && (rsp_cause == 4'd6));

   a_r6_fetch_not_device: assert property (@(posedge clk) disable iff (!rst_n)
      accept && req_fetch && !req_write |=> !dev_req_valid);
endmodule

bind mem_route_unit mem_route_checker #(.AW (AW), .DW (DW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr      (req_addr),
   .req_size      (req_size),
   .req_fetch     (req_fetch),
   .req_write     (req_write),
   .req_aq        (req_aq),
   .req_rl        (req_rl),
   .req_rsv       (req_rsv),
   .rsp_valid     (rsp_valid),
   .rsp_ready     (rsp_ready),
   .rsp_rdata     (rsp_rdata),
   .rsp_err       (rsp_err),
   .rsp_cause     (rsp_cause),
   .dev_req_valid (dev_req_valid),
   .dev_req_ready (dev_req_ready),
   .dev_addr      (dev_addr),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_addr      (mem_addr)
);

// File: tb/mem_route_unit_bench.sv
`timescale 1ns/1ps
module mem_route_unit_bench;
   localparam int AW = 16;
   localparam int DW = 64;
   localparam int MB = 16'h1000, ML = 16'h1FFF;
   localparam int RB = 16'h0100, RL = 16'h01FF;
   localparam int WB = 16'h0180, WL = 16'h027F;
   localparam int OK_LAST = 16'h1EFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0;
   logic          req_aq = 1'b0, req_rl = 1'b0, req_rsv = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready;
   logic          rsp_valid, rsp_err;
   logic          rsp_ready = 1'b0;
   logic [DW-1:0] rsp_rdata;
   logic [3:0]    rsp_cause;
   logic          dev_req_valid, dev_write;
   logic          dev_req_ready = 1'b0, dev_rsp_valid = 1'b0;
   logic [AW-1:0] dev_addr;
   logic [1:0]    dev_size;
   logic [DW-1:0] dev_wdata;
   logic [DW-1:0] dev_rsp_rdata = '0;
   logic          mem_req_valid, mem_write;
   logic          mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_size;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rsp_rdata = '0;

   int n_chk = 0, n_fail = 0, lat = 0, cycles = 0;
   int dev_hits = 0, mem_hits = 0;
   logic [AW-1:0] seen_addr;
   logic [1:0]    seen_size;
   logic          seen_write;
   logic [DW-1:0] seen_wdata;

   always #2.5 clk = ~clk;

   mem_route_unit #(
      .AW (AW), .DW (DW),
      .MEM_BASE (16'(MB)), .MEM_LAST (16'(ML)),
      .DRD_BASE (16'(RB)), .DRD_LAST (16'(RL)),
      .DWR_BASE (16'(WB)), .DWR_LAST (16'(WL))
   ) u_mem_route_unit (.*);

   task automatic chk(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
         end
      end
   end

   // device responder: never rejects, returns inverted address pattern
   initial begin
      forever begin
         @(negedge clk);
         dev_rsp_valid = 1'b0;
         if (dev_req_valid) begin
            repeat (lat) @(negedge clk);
            dev_req_ready = 1'b1;
            seen_addr = dev_addr; seen_size = dev_size;
            seen_write = dev_write; seen_wdata = dev_wdata;
            dev_hits++;
            @(negedge clk);
            dev_req_ready = 1'b0;
            dev_rsp_valid = 1'b1;
            dev_rsp_rdata = {4{~seen_addr}};
         end
      end
   end

   // memory responder: accepts only first bytes in [MB, OK_LAST]
   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (mem_req_valid) begin
            repeat (lat) @(negedge clk);
            mem_req_ready = 1'b1;
            seen_addr = mem_addr; seen_size = mem_size;
            seen_write = mem_write; seen_wdata = mem_wdata;
            mem_hits++;
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b1;
            mem_rsp_err   = !(int'(seen_addr) >= MB && int'(seen_addr) <= OK_LAST);
            mem_rsp_rdata = {4{seen_addr}};
         end
      end
   end

   function automatic bit inwin(input int a, input int n, input int b, input int l);
      return (a >= b) && (a + n - 1 <= l);
   endfunction

   task automatic run(input int a, input int sz, input bit f, input bit w,
                      input bit q, input bit r, input bit s, input bit hold);
      int n = 1 << sz;
      bit mis = (a % n) != 0;
      bit ord = q | r | s;
      int port = 0;
      bit exp_err = 1'b0;
      int exp_cause = 0;
      logic [DW-1:0] exp_data = '0;
      string tag;
      int dh0 = dev_hits, mh0 = mem_hits, wd = 0;
      logic [DW-1:0] wdat = {16'(a), ~16'(a), 16'hA5C3, 8'(sz), 3'b0, f, w, q, r, s};
      logic [DW-1:0] cap_data;
      logic          cap_err;
      logic [3:0]    cap_cause;
      bit            straddle;

      if (w) begin
         if ((r | s) && mis)               begin exp_err = 1; exp_cause = 6; end
         else if (ord)                     port = 2;
         else if (inwin(a, n, WB, WL))     port = 1;
         else if (inwin(a, n, MB, ML))     port = 2;
         else                              begin exp_err = 1; exp_cause = 7; end
      end else begin
         if ((q | s) && mis)               begin exp_err = 1; exp_cause = 4; end
         else if (ord)                     port = 2;
         else if (!f && inwin(a, n, RB, RL)) port = 1;
         else if (inwin(a, n, MB, ML))     port = 2;
         else                              begin exp_err = 1; exp_cause = 5; end
      end
      if (port == 2 && !(a >= MB && a <= OK_LAST)) begin
         exp_err = 1;
         exp_cause = w ? 7 : (f ? 1 : 5);
      end
      if (!exp_err && !w)
         exp_data = (port == 1) ? {4{~16'(a)}} : {4{16'(a)}};

      straddle = (inwin(a, 1, RB, RL) != inwin(a, n, RB, RL)) ||
                 (inwin(a, 1, WB, WL) != inwin(a, n, WB, WL)) ||
                 (inwin(a, 1, MB, ML) != inwin(a, n, MB, ML));
      if (!w && (q | s) && mis)            tag = "R2";
      else if (w && (r | s) && mis)        tag = "R3";
      else if (ord && sz > 0 && (w ? (r | s) : (q | s))) tag = "R1";
      else if (ord)                        tag = "R4";
      else if (straddle)                   tag = "R9";
      else if (w)                          tag = "R8";
      else if (port == 1)                  tag = "R5";
      else if (port == 2 && exp_err)       tag = "R7";
      else                                 tag = "R6";

      @(negedge clk);
      req_addr = 16'(a); req_size = 2'(sz); req_fetch = f; req_write = w;
      req_aq = q; req_rl = r; req_rsv = s; req_wdata = wdat; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (hold) chk("R10", "ready low while busy", 64'(req_ready), 64'd0);
      while (!rsp_valid && wd < 60) begin @(negedge clk); wd++; end
      chk(tag, "response arrives", 64'(rsp_valid), 64'd1);
      cap_data = rsp_rdata; cap_err = rsp_err; cap_cause = rsp_cause;
      if (hold) begin
         repeat (2) @(negedge clk);
         chk("R10", "valid held", 64'(rsp_valid), 64'd1);
         chk("R10", "data held", rsp_rdata, cap_data);
         chk("R10", "cause held", {59'd0, rsp_err, rsp_cause}, {59'd0, cap_err, cap_cause});
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;

      chk(tag, "device port used", 64'(dev_hits - dh0), 64'(port == 1));
      chk(tag, "memory port used", 64'(mem_hits - mh0), 64'(port == 2));
      chk(tag, "error flag", 64'(cap_err), 64'(exp_err));
      chk(tag, "cause", 64'(cap_cause), exp_err ? 64'(exp_cause) : 64'(0));
      chk((w || exp_err) ? "R10" : tag, "read data", cap_data, exp_data);
      if (port != 0) begin
         chk("R11", "fwd addr", 64'(seen_addr), 64'(a));
         chk("R11", "fwd size", 64'(seen_size), 64'(sz));
         chk("R11", "fwd dir", 64'(seen_write), 64'(w));
         chk("R11", "fwd wdata", seen_wdata, wdat);
      end
   endtask

   initial begin
      int bases[8] = '{16'h00FC, 16'h01FA, 16'h017C, 16'h027A,
                       16'h0FFA, 16'h1EFA, 16'h1FF8, 16'hFFF8};
      int idx = 0;
      repeat (3) @(negedge clk);
      chk("R12", "ready after reset", 64'(req_ready), 64'd1);
      chk("R12", "no valids after reset",
          {61'd0, rsp_valid, dev_req_valid, mem_req_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12", "ready out of reset", 64'(req_ready), 64'd1);
      for (int b = 0; b < 8; b++) begin
         for (int o = 0; o < 9; o++) begin
            for (int sz = 0; sz < 4; sz++) begin
               for (int m = 0; m < 32; m++) begin
                  if (!(m[1] && m[0])) begin
                     lat = idx % 3;
                     run((bases[b] + o) & 16'hFFFF, sz, m[1], m[0],
                         m[2], m[3], m[4], (idx % 7) == 0);
                     idx++;
                  end
               end
            end
         end
      end
      finish_run();
   end
endmodule